// File: doc/BRIEF.md
# Microstep Current Profile Sequencer

This block produces the per-step current targets for the two windings of a bipolar stepper motor. A position counter spans one electrical cycle as 32 microsteps. A rising edge on the step input moves it forward or back by a stride that depends on the selected stepping mode. The position reads a programmable nine-entry quarter-wave table. The lookup is mirrored inside each half cycle and sign-folded across the two halves, so a quarter wave is enough to describe a whole cycle. Winding B reads the same table a quarter cycle (8 positions) ahead of winding A. A 3-bit full-scale code scales both magnitudes. The downstream bridge controllers receive an 8-bit magnitude, a polarity bit and a decay choice for each winding.

Decay can be fixed to slow, fast or mixed, or it can be left automatic. In automatic mode, each winding compares the magnitude it has now with the one it will have after the next step in the current mode and direction. A rising or unchanged magnitude selects slow decay. A falling magnitude selects fast decay. When the enable input is low, every register clears, including the table. Both windings are then forced off: magnitude 0, positive polarity, slow decay.

Table entries arrive on a valid/ready write stream. Ready equals enable. A beat transfers on any cycle where valid and ready are both high, and takes effect from the next clock edge. The port holds no storage, so a producer facing a low ready simply keeps valid and its data steady until ready returns.

Top module: `microstep_seq`

## Requirements
- R1: While `en` is low the winding outputs are forced off (magnitudes 0, polarity bits 0, decay codes 0), and at each clock edge the position, edge detector and all nine table entries clear to 0. Asynchronous `rst_n` low has the same effect.
- R2: Each rising edge of `step_in` seen while enabled moves `pos` by a stride set by `step_mode`: 0 gives 8 (full), 1 gives 4 (half), 2 gives 2 (mini) and 3 gives 1 (micro). A step input held high for several cycles counts only once.
- R3: With `dir` = 0 the position counts up, and with `dir` = 1 it counts down, wrapping modulo 32 in both directions.
- R4: Winding A reads table index L when L = pos mod 16 is 8 or less, and index 16 − L otherwise. `a_neg` equals 1 exactly when pos is 16 or more.
- R5: Winding B applies the rule of R4 to position (pos + 8) mod 32 and drives `b_mag`/`b_neg`.
- R6: Each magnitude equals floor(entry × (`fs_code` + 1) / 8), zero-extended to 8 bits.
- R7: `decay_sel` codes 0 (slow), 1 (fast) and 2 (mixed) are driven unchanged onto both `a_decay` and `b_decay`, which use the same codes.
- R8: With `decay_sel` = 3 (automatic), each winding computes its magnitude at the position the next step would reach under the present mode and direction. The winding outputs code 1 (fast) if that magnitude is smaller than the present one, and code 0 (slow) if it is larger or equal.
- R9: `tbl_wr_ready` equals `en`. An accepted beat with `tbl_wr_idx` 0..8 writes `tbl_wr_data` to that entry. Beats with index 9..15 change no entry.
- R10: `step_start` is high for exactly the one cycle in which `pos` first shows the stepped value. The position holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low clears all state and turns the windings off |
| step_in | input | 1 | Step clock, rising edge advances the position |
| dir | input | 1 | 0 counts up, 1 counts down |
| step_mode | input | 2 | 0 full, 1 half, 2 mini, 3 micro |
| decay_sel | input | 2 | 0 slow, 1 fast, 2 mixed, 3 automatic |
| fs_code | input | 3 | Full-scale code, scale (code+1)/8 |
| tbl_wr_valid | input | 1 | Table write beat valid |
| tbl_wr_ready | output | 1 | Table write port ready (equals en) |
| tbl_wr_idx | input | 4 | Table entry index |
| tbl_wr_data | input | 5 | Table entry value |
| pos | output | 5 | Current position within the electrical cycle |
| step_start | output | 1 | One-cycle pulse when a new position takes effect |
| a_mag | output | 8 | Winding A current magnitude |
| a_neg | output | 1 | Winding A polarity, 1 = negative |
| a_decay | output | 2 | Winding A decay code |
| b_mag | output | 8 | Winding B current magnitude |
| b_neg | output | 1 | Winding B polarity, 1 = negative |
| b_decay | output | 2 | Winding B decay code |

## Verification
The main function is tried with three patterns. The first is a microstep sweep through positions 1 to 21, which crosses the mirror point at 8 and the sign change at 16. This catches errors in the fold and in the polarity for each winding, and with an asymmetric table it also catches a swapped or missing quarter-cycle offset. The second is a set of half-, full- and mini-step runs in both directions that wrap through 0. These separate stride-by-mode mistakes from wrap and direction mistakes, and a step pulse held high over several cycles tells edge detection apart from level sensing. The automatic decay cases use a table with two equal neighbouring entries to produce rising, falling and flat transitions. A low full-scale code makes truncation visible, and a write to an index past the table end followed by a look at the entry its low bits alias shows that such a write is dropped.

// File: rtl/msq_pkg.sv
`timescale 1ns/1ps
package msq_pkg;
  typedef enum logic [1:0] {
    STEP_FULL  = 2'd0,
    STEP_HALF  = 2'd1,
    STEP_MINI  = 2'd2,
    STEP_MICRO = 2'd3
  } step_mode_e;

  typedef enum logic [1:0] {
    DCY_SLOW  = 2'd0,
    DCY_FAST  = 2'd1,
    DCY_MIXED = 2'd2,
    DCY_AUTO  = 2'd3
  } decay_e;
endpackage

// File: rtl/msq_table.sv
`timescale 1ns/1ps
module msq_table #(
  parameter int N_ENT = 9,
  parameter int ENT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [ENT_W-1:0]            wr_data,
  output logic [N_ENT-1:0][ENT_W-1:0] entries
);
  // The write port never stalls while enabled; out-of-range beats are dropped.
  assign wr_ready = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entries <= '0;
    end else if (!en) begin
      entries <= '0;
    end else if (wr_valid && wr_ready) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (wr_idx == IDX_W'(i)) entries[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/msq_pos_ctr.sv
`timescale 1ns/1ps
module msq_pos_ctr #(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_in,
  input  logic             dir,
  input  logic [1:0]       step_mode,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_next,
  output logic             step_start
);
  import msq_pkg::*;

  localparam int QUARTER = 1 << (POS_W - 2);

  logic             step_q;
  logic             rise;
  logic [POS_W-1:0] stride;
  step_mode_e       mode;

  always_comb begin
    mode = step_mode_e'(step_mode);
    unique case (mode)
      STEP_FULL:  stride = POS_W'(QUARTER);
      STEP_HALF:  stride = POS_W'(QUARTER >> 1);
      STEP_MINI:  stride = POS_W'(QUARTER >> 2);
      default:    stride = POS_W'(QUARTER >> 3);
    endcase
    pos_next = dir ? (pos - stride) : (pos + stride);
    rise     = step_in & ~step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      step_q     <= 1'b0;
      step_start <= 1'b0;
    end else if (!en) begin
      pos        <= '0;
      step_q     <= 1'b0;
      step_start <= 1'b0;
    end else begin
      step_q     <= step_in;
      step_start <= rise;
      if (rise) pos <= pos_next;
    end
  end
endmodule

// File: rtl/msq_winding.sv
`timescale 1ns/1ps
module msq_winding #(
  parameter int POS_W  = 5,
  parameter int N_ENT  = 9,
  parameter int ENT_W  = 5,
  parameter int FS_W   = 3,
  parameter int MAG_W  = 8,
  parameter int OFFSET = 0
) (
  input  logic                        en,
  input  logic [POS_W-1:0]            pos,
  input  logic [POS_W-1:0]            pos_next,
  input  logic [N_ENT-1:0][ENT_W-1:0] entries,
  input  logic [FS_W-1:0]             fs_code,
  input  logic [1:0]                  decay_sel,
  output logic [MAG_W-1:0]            mag,
  output logic                        neg,
  output logic [1:0]                  decay
);
  import msq_pkg::*;

  localparam int HALF    = 1 << (POS_W - 1);
  localparam int QUARTER = 1 << (POS_W - 2);
  localparam int IDX_W   = $clog2(N_ENT);
  localparam int PROD_W  = ENT_W + FS_W + 1;

  // Mirror a position within its half cycle onto the quarter-wave index.
  function automatic logic [IDX_W-1:0] fold_idx(input logic [POS_W-1:0] p);
    logic [POS_W-1:0] low;
    low = {1'b0, p[POS_W-2:0]};
    if (low <= POS_W'(QUARTER)) fold_idx = IDX_W'(low);
    else                        fold_idx = IDX_W'(POS_W'(HALF) - low);
  endfunction

  function automatic logic [MAG_W-1:0] scale(input logic [ENT_W-1:0] e,
                                             input logic [FS_W-1:0]  f);
    logic [PROD_W-1:0] prod;
    prod  = PROD_W'(e) * (PROD_W'(f) + PROD_W'(1));
    scale = MAG_W'(prod >> FS_W);
  endfunction

  logic [POS_W-1:0] my_pos, my_next;
  logic [MAG_W-1:0] cur_mag, nxt_mag;
  decay_e           dsel, dchoice;

  always_comb begin
    my_pos  = pos + POS_W'(OFFSET);
    my_next = pos_next + POS_W'(OFFSET);
    cur_mag = scale(entries[fold_idx(my_pos)], fs_code);
    nxt_mag = scale(entries[fold_idx(my_next)], fs_code);
    dsel    = decay_e'(decay_sel);
    if (dsel == DCY_AUTO) dchoice = (nxt_mag < cur_mag) ? DCY_FAST : DCY_SLOW;
    else                  dchoice = dsel;
  end

  assign mag   = en ? cur_mag : '0;
  assign neg   = en & my_pos[POS_W-1];
  assign decay = en ? 2'(dchoice) : 2'(DCY_SLOW);
endmodule

// File: rtl/microstep_seq.sv
`timescale 1ns/1ps
module microstep_seq #(
  parameter int POS_W = 5,
  parameter int ENT_W = 5,
  parameter int FS_W  = 3,
  parameter int MAG_W = 8,
  localparam int N_ENT = (1 << (POS_W - 2)) + 1,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_in,
  input  logic             dir,
  input  logic [1:0]       step_mode,
  input  logic [1:0]       decay_sel,
  input  logic [FS_W-1:0]  fs_code,
  input  logic             tbl_wr_valid,
  output logic             tbl_wr_ready,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic [ENT_W-1:0] tbl_wr_data,
  output logic [POS_W-1:0] pos,
  output logic             step_start,
  output logic [MAG_W-1:0] a_mag,
  output logic             a_neg,
  output logic [1:0]       a_decay,
  output logic [MAG_W-1:0] b_mag,
  output logic             b_neg,
  output logic [1:0]       b_decay
);
  localparam int QUARTER = 1 << (POS_W - 2);
  localparam int N_WIND  = 2;

  logic [N_ENT-1:0][ENT_W-1:0] entries;
  logic [POS_W-1:0]            pos_next;
  logic [MAG_W-1:0]            w_mag [N_WIND];
  logic                        w_neg [N_WIND];
  logic [1:0]                  w_dcy [N_WIND];

  msq_table #(.N_ENT(N_ENT), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_valid(tbl_wr_valid), .wr_ready(tbl_wr_ready),
    .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
    .entries(entries)
  );

  msq_pos_ctr #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(en),
    .step_in(step_in), .dir(dir), .step_mode(step_mode),
    .pos(pos), .pos_next(pos_next), .step_start(step_start)
  );

  // Each winding reads the table one quarter cycle after the previous one.
  for (genvar w = 0; w < N_WIND; w++) begin : g_wind
    msq_winding #(
      .POS_W(POS_W), .N_ENT(N_ENT), .ENT_W(ENT_W),
      .FS_W(FS_W), .MAG_W(MAG_W), .OFFSET(w * QUARTER)
    ) u_wind (
      .en(en), .pos(pos), .pos_next(pos_next), .entries(entries),
      .fs_code(fs_code), .decay_sel(decay_sel),
      .mag(w_mag[w]), .neg(w_neg[w]), .decay(w_dcy[w])
    );
  end

  assign a_mag   = w_mag[0];
  assign a_neg   = w_neg[0];
  assign a_decay = w_dcy[0];
  assign b_mag   = w_mag[1];
  assign b_neg   = w_neg[1];
  assign b_decay = w_dcy[1];
endmodule

// File: rtl/microstep_seq_chk.sv
`timescale 1ns/1ps
module microstep_seq_chk #(
  parameter int POS_W = 5,
  parameter int MAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dir,
  input logic [1:0]       step_mode,
  input logic [1:0]       decay_sel,
  input logic             tbl_wr_ready,
  input logic [POS_W-1:0] pos,
  input logic             step_start,
  input logic [MAG_W-1:0] a_mag,
  input logic             a_neg,
  input logic [1:0]       a_decay,
  input logic [MAG_W-1:0] b_mag,
  input logic             b_neg,
  input logic [1:0]       b_decay
);
  localparam int QUARTER = 1 << (POS_W - 2);

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (a_mag == '0 && b_mag == '0 && !a_neg && !b_neg &&
             a_decay == 2'd0 && b_decay == 2'd0));

  p_pos_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pos == '0);

  p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> pos == ($past(dir)
      ? $past(pos) - POS_W'(QUARTER >> $past(step_mode))
      : $past(pos) + POS_W'(QUARTER >> $past(step_mode))));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !step_start) |-> $stable(pos));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_ready == en);

  p_fixed_decay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && decay_sel != 2'd3) |-> (a_decay == decay_sel && b_decay == decay_sel));

  p_auto_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && decay_sel == 2'd3) |-> (a_decay != 2'd2 && a_decay != 2'd3 &&
                                   b_decay != 2'd2 && b_decay != 2'd3));
endmodule

bind microstep_seq microstep_seq_chk #(.POS_W(POS_W), .MAG_W(MAG_W)) u_chk (.*);

// File: tb/tb_microstep_seq.sv
`timescale 1ns/1ps
module tb_microstep_seq;
  logic       clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b0, step_in = 1'b0, dir = 1'b0;
  logic [1:0] step_mode = 2'd3, decay_sel = 2'd0;
  logic [2:0] fs_code = 3'd7;
  logic       tbl_wr_valid = 1'b0;
  logic [3:0] tbl_wr_idx = '0;
  logic [4:0] tbl_wr_data = '0;
  logic       tbl_wr_ready, step_start, a_neg, b_neg;
  logic [4:0] pos;
  logic [7:0] a_mag, b_mag;
  logic [1:0] a_decay, b_decay;

  microstep_seq dut (
    .clk(clk), .rst_n(rst_n), .en(en), .step_in(step_in), .dir(dir),
    .step_mode(step_mode), .decay_sel(decay_sel), .fs_code(fs_code),
    .tbl_wr_valid(tbl_wr_valid), .tbl_wr_ready(tbl_wr_ready),
    .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .pos(pos), .step_start(step_start),
    .a_mag(a_mag), .a_neg(a_neg), .a_decay(a_decay),
    .b_mag(b_mag), .b_neg(b_neg), .b_decay(b_decay)
  );

  typedef struct {
    string tag;
    int am, bm, an, bn, ad, bd, p, ss, rdy;
  } exp_t;

  exp_t q[$];
  int   m_tbl[9];
  int   m_pos = 0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  function automatic int fold(int p);
    int l;
    l = p % 16;
    return (l <= 8) ? l : 16 - l;
  endfunction

  function automatic int mag_at(int p);
    return (m_tbl[fold(p % 32)] * (int'(fs_code) + 1)) / 8;
  endfunction

  function automatic int stride();
    return 8 >> int'(step_mode);
  endfunction

  function automatic int next_pos();
    return dir ? (m_pos - stride() + 32) % 32 : (m_pos + stride()) % 32;
  endfunction

  function automatic int dcy(int cur, int nxt);
    if (decay_sel != 2'd3) return int'(decay_sel);
    return (nxt < cur) ? 1 : 0;
  endfunction

  // Driver side: the expected item reflects the state after the last edge.
  task automatic push(string tag, int ss);
    exp_t e;
    int   pb, nb;
    e.tag = tag;
    if (!en) begin
      e.am = 0; e.bm = 0; e.an = 0; e.bn = 0; e.ad = 0; e.bd = 0;
      e.p = 0; e.ss = 0; e.rdy = 0;
    end else begin
      pb    = (m_pos + 8) % 32;
      nb    = (next_pos() + 8) % 32;
      e.am  = mag_at(m_pos);
      e.bm  = mag_at(pb);
      e.an  = (m_pos >= 16) ? 1 : 0;
      e.bn  = (pb >= 16) ? 1 : 0;
      e.ad  = dcy(mag_at(m_pos), mag_at(next_pos()));
      e.bd  = dcy(mag_at(pb), mag_at(nb));
      e.p   = m_pos; e.ss = ss; e.rdy = 1;
    end
    q.push_back(e);
  endtask

  task automatic drive_slot();
    @(negedge clk); #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic set_cfg(string tag, int md, int d, int ds, int fs);
    drive_slot();
    step_mode = 2'(md); dir = d[0]; decay_sel = 2'(ds); fs_code = 3'(fs);
    after_edge();
    push(tag, 0);
  endtask

  task automatic wr(string tag, int idx, int data);
    drive_slot();
    tbl_wr_valid = 1'b1; tbl_wr_idx = 4'(idx); tbl_wr_data = 5'(data);
    after_edge();
    if (en && idx < 9) m_tbl[idx] = data;
    tbl_wr_valid = 1'b0;
    push(tag, 0);
  endtask

  task automatic step(string tag, bit hold);
    drive_slot();
    step_in = 1'b1;
    after_edge();
    m_pos = next_pos();
    push(tag, 1);
    if (hold) begin
      after_edge();
      push(tag, 0);
      after_edge();
      push(tag, 0);
    end
    drive_slot();
    step_in = 1'b0;
    after_edge();
    push(tag, 0);
  endtask

  task automatic set_en(string tag, bit v);
    drive_slot();
    en = v;
    after_edge();
    if (!v) begin
      m_pos = 0;
      for (int i = 0; i < 9; i++) m_tbl[i] = 0;
    end
    push(tag, 0);
  endtask

  // Monitor: samples on the falling edge, before the driver moves inputs.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(a_mag) != e.am || int'(b_mag) != e.bm || int'(a_neg) != e.an ||
          int'(b_neg) != e.bn || int'(a_decay) != e.ad || int'(b_decay) != e.bd ||
          int'(pos) != e.p || int'(step_start) != e.ss || int'(tbl_wr_ready) != e.rdy) begin
        fails++;
        $display("FAIL %s: got am=%0d bm=%0d an=%0d bn=%0d ad=%0d bd=%0d pos=%0d ss=%0d rdy=%0d exp am=%0d bm=%0d an=%0d bn=%0d ad=%0d bd=%0d pos=%0d ss=%0d rdy=%0d",
          e.tag, a_mag, b_mag, a_neg, b_neg, a_decay, b_decay, pos, step_start, tbl_wr_ready,
          e.am, e.bm, e.an, e.bn, e.ad, e.bd, e.p, e.ss, e.rdy);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int sv[9] = '{0, 6, 12, 17, 22, 26, 29, 31, 31};
    for (int i = 0; i < 9; i++) m_tbl[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    push("R1", 0);                       // reset state, disabled
    set_en("R1", 1'b1);                  // enabled, table still clear
    for (int i = 0; i < 9; i++) wr("R9", i, sv[i]);
    wr("R9", 12, 5);                     // index past the table end: dropped
    set_cfg("R8", 3, 0, 3, 7);           // microstep, up, automatic decay
    for (int k = 1; k <= 20; k++) begin
      if (k == 4)      step("R9", 1'b0); // entry 4 still 22 after the dropped write
      else if (k == 7) step("R8", 1'b0); // equal next magnitude -> slow
      else if (k < 16) step("R4", 1'b0);
      else             step("R5", 1'b0);
    end
    step("R10", 1'b1);                   // held high: counts once
    set_cfg("R3", 1, 1, 3, 7);           // half step, down
    for (int k = 0; k < 6; k++) step("R3", 1'b0);
    set_cfg("R2", 0, 0, 3, 7);           // full step, up, wraps
    for (int k = 0; k < 4; k++) step("R2", 1'b0);
    set_cfg("R2", 2, 1, 3, 7);           // mini step, down
    for (int k = 0; k < 3; k++) step("R2", 1'b0);
    set_cfg("R7", 3, 0, 0, 7);
    step("R7", 1'b0);
    set_cfg("R7", 3, 0, 1, 7);
    step("R7", 1'b0);
    set_cfg("R7", 3, 0, 2, 7);
    step("R7", 1'b0);
    set_cfg("R6", 3, 0, 3, 0);
    step("R6", 1'b0);
    set_cfg("R6", 3, 0, 3, 3);
    step("R6", 1'b0);
    set_en("R1", 1'b0);
    set_en("R1", 1'b1);                  // table and position cleared
    step("R1", 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule